// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide host side of a three-channel interval timer. A two-bit address picks either one of three channel data ports (0, 1, 2) or the control port (3). The block turns control bytes into per-channel configuration: byte access style, counting mode and decimal flag. It assembles count values from one or two data-port writes and hands each completed value to its channel as a one-cycle load pulse. On the read side it returns bytes of the channel's live count, a frozen copy of that count, or a status snapshot, in a fixed priority order.

The counting datapath sits outside this block. Each channel presents its running count and output level as inputs. The block presents the count to load, the mode and the decimal flag, plus a one-cycle pulse that marks each reprogramming. `bus_rdata` is combinational. It shows the byte that a read strobe in the current cycle would consume. The strobe advances the sequencing at the next rising clock edge.

Each channel holds three named state machines. The write sequencer has states `SEQ_LO` and `SEQ_HI`. It moves `SEQ_LO -> SEQ_HI` on the first write in word access and `SEQ_HI -> SEQ_LO` on the second write, and reprogramming forces it back to `SEQ_LO`. The live-read sequencer uses the same two states and toggles on each unlatched read in word access. The count-latch machine has states `LAT_NONE`, `LAT_LO`, `LAT_HI` and `LAT_WORD`. A latch command moves it out of `LAT_NONE` into the state that matches the access style. A read moves `LAT_WORD -> LAT_HI`, and a read in `LAT_LO` or `LAT_HI` returns it to `LAT_NONE`. A status flag beside the count-latch machine is set by a status latch and cleared by a read.

Top module: `tmr_regif`

## Requirements
- R1: In a control byte (address 3), bits 7:6 pick the channel (3 means read-back). Bits 5:4 pick the access style: 1 is low byte only, 2 is high byte only, 3 is low then high. Bits 3:1 give the mode and bit 0 the decimal flag. When bits 7:6 are 0 to 2 and bits 5:4 are not 0, the channel's `ch_mode` and `ch_bcd` take the new values and its `ch_cfg_wr` bit pulses for one cycle, all in the cycle after the write.
- R2: Mode codes 6 and 7 are stored and reported as 2 and 3. `ch_mode` never holds 6 or 7.
- R3: A data-port write loads the channel as follows. In low-only access the count is {0x00, byte}. In high-only access it is {byte, 0x00}. In word access the first write is held and the second write loads {second, first}. Each load shows as a one-cycle `ch_load` pulse with `ch_load_val`, in the cycle after the loading write. Only one channel loads at a time.
- R4: A control byte with non-zero access returns both the write and the live-read sequencing of that channel to the low byte.
- R5: An unlatched read returns bits 7:0 of the live count in low-only access and bits 15:8 in high-only access. In word access reads alternate, starting with the low byte.
- R6: A control byte with bits 5:4 equal to 0 freezes the channel's live count. The command is ignored while a frozen count of that channel is still unread.
- R7: A frozen count is read in the channel's access order. Low-only gives the low byte, high-only gives the high byte, word gives low then high. After that it is released, and reads return the live count again.
- R8: In read-back (bits 7:6 = 3), bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the count and bit 4 = 0 captures the status of every selected channel in the same write.
- R9: The status byte is {output level, 0, access[1:0], mode[2:0], decimal}. A status capture is ignored while a captured status of that channel is unread. A pending status is returned before a frozen count, and one read releases it.
- R10: A read-back byte that selects no channel changes nothing: no `ch_cfg_wr` pulse, and no frozen count or status appears.
- R11: After reset every channel has access code 0, which behaves as low byte only. Mode and decimal flag are 0, and nothing is frozen or captured. Reading address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 to 2 data ports, 3 control |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe; consumes the byte on `bus_rdata` |
| bus_rdata | output | 8 | Byte a read in this cycle returns |
| ch_count | input | 48 | Live 16-bit counts, channel i at bits 16i+15:16i |
| ch_out | input | 3 | Channel output levels |
| ch_load | output | 3 | One-cycle count-load pulse per channel |
| ch_load_val | output | 48 | Count to load, channel i at bits 16i+15:16i |
| ch_mode | output | 9 | Mode per channel, channel i at bits 3i+2:3i |
| ch_bcd | output | 3 | Decimal counting flag per channel |
| ch_cfg_wr | output | 3 | One-cycle pulse when a channel is reprogrammed |

## Verification
The assertions assume that the host raises at most one write per cycle. A control write therefore never shares a cycle with a data write, and the rule that a load or configuration pulse always traces back to a matching write of the previous cycle relies on this. They also assume that the host never reads and sends a latch command to the same channel in the same cycle. The bench drives every strobe for exactly one cycle from the falling edge, never overlaps a read with a write, and changes the stub live counts only between accesses. Reads and latch commands therefore stay sequential.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int ADDR_W  = 2;
    localparam int NUM_CH  = (1 << ADDR_W) - 1;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int MODE_W  = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;

    typedef enum logic [1:0] {
        LAT_NONE = 2'd0,
        LAT_LO   = 2'd1,
        LAT_HI   = 2'd2,
        LAT_WORD = 2'd3
    } lat_e;

    typedef struct packed {
        logic              prog;
        logic              latch_cnt;
        logic              latch_stat;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cmd_t;

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_regif_pkg::*;
(
    input  logic                     ctrl_wr,
    input  logic [BYTE_W-1:0]        ctrl_byte,
    output chan_cmd_t [NUM_CH-1:0]   cmd
);

    localparam logic [1:0] SEL_RB = 2'd3;

    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode_n;
    logic              rb;

    always_comb begin
        sel    = ctrl_byte[7:6];
        acc    = acc_e'(ctrl_byte[5:4]);
        rb     = (sel == SEL_RB);
        // fold the two aliased codes onto their base modes
        if (ctrl_byte[3:2] == 2'b11) mode_n = {1'b0, ctrl_byte[2:1]};
        else                         mode_n = ctrl_byte[3:1];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [1:0] MY_SEL = 2'(i);
        always_comb begin
            cmd[i].acc        = acc;
            cmd[i].mode       = mode_n;
            cmd[i].bcd        = ctrl_byte[0];
            cmd[i].prog       = 1'b0;
            cmd[i].latch_cnt  = 1'b0;
            cmd[i].latch_stat = 1'b0;
            if (ctrl_wr) begin
                if (rb) begin
                    if (ctrl_byte[1+i]) begin
                        cmd[i].latch_cnt  = ~ctrl_byte[5];
                        cmd[i].latch_stat = ~ctrl_byte[4];
                    end
                end else if (sel == MY_SEL) begin
                    if (acc == ACC_LATCH) cmd[i].latch_cnt = 1'b1;
                    else                  cmd[i].prog      = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  acc_e              acc,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);

    seq_e              st_q, st_d;
    logic [BYTE_W-1:0] hold_q, hold_d;
    logic              load_d;
    logic [CNT_W-1:0]  val_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SEQ_LO;
            hold_q   <= '0;
            load     <= 1'b0;
            load_val <= '0;
        end else begin
            st_q     <= st_d;
            hold_q   <= hold_d;
            load     <= load_d;
            load_val <= val_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        hold_d = hold_q;
        load_d = 1'b0;
        val_d  = load_val;
        if (prog) begin
            st_d = SEQ_LO;
        end else if (data_wr) begin
            unique case (acc)
                ACC_HI: begin
                    load_d = 1'b1;
                    val_d  = {wbyte, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    unique case (st_q)
                        SEQ_LO: begin
                            hold_d = wbyte;
                            st_d   = SEQ_HI;
                        end
                        SEQ_HI: begin
                            load_d = 1'b1;
                            val_d  = {wbyte, hold_q};
                            st_d   = SEQ_LO;
                        end
                    endcase
                end
                ACC_LO, ACC_LATCH: begin
                    load_d = 1'b1;
                    val_d  = {{BYTE_W{1'b0}}, wbyte};
                end
            endcase
        end
    end

endmodule

// File: rtl/tmr_rd_port.sv
module tmr_rd_port
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              latch_cnt,
    input  logic              latch_stat,
    input  acc_e              acc,
    input  logic [MODE_W-1:0] mode,
    input  logic              bcd,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    input  logic              pop,
    output logic [BYTE_W-1:0] rbyte
);

    lat_e              lat_q, lat_d;
    logic [CNT_W-1:0]  frz_q, frz_d;
    seq_e              rseq_q, rseq_d;
    logic              sv_q, sv_d;
    logic [BYTE_W-1:0] stat_q, stat_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= LAT_NONE;
            frz_q  <= '0;
            rseq_q <= SEQ_LO;
            sv_q   <= 1'b0;
            stat_q <= '0;
        end else begin
            lat_q  <= lat_d;
            frz_q  <= frz_d;
            rseq_q <= rseq_d;
            sv_q   <= sv_d;
            stat_q <= stat_d;
        end
    end

    // transitions
    always_comb begin
        lat_d  = lat_q;
        frz_d  = frz_q;
        rseq_d = rseq_q;
        sv_d   = sv_q;
        stat_d = stat_q;
        if (pop) begin
            if (sv_q) begin
                sv_d = 1'b0;
            end else begin
                unique case (lat_q)
                    LAT_NONE: if (acc == ACC_WORD)
                                  rseq_d = (rseq_q == SEQ_LO) ? SEQ_HI : SEQ_LO;
                    LAT_LO:   lat_d = LAT_NONE;
                    LAT_HI:   lat_d = LAT_NONE;
                    LAT_WORD: lat_d = LAT_HI;
                endcase
            end
        end
        if (prog) rseq_d = SEQ_LO;
        if (latch_cnt && lat_q == LAT_NONE) begin
            frz_d = live;
            unique case (acc)
                ACC_HI:            lat_d = LAT_HI;
                ACC_WORD:          lat_d = LAT_WORD;
                ACC_LO, ACC_LATCH: lat_d = LAT_LO;
            endcase
        end
        if (latch_stat && !sv_q) begin
            sv_d   = 1'b1;
            stat_d = {out_lvl, 1'b0, acc, mode, bcd};
        end
    end

    // output byte
    always_comb begin
        if (sv_q) begin
            rbyte = stat_q;
        end else begin
            unique case (lat_q)
                LAT_LO, LAT_WORD: rbyte = frz_q[BYTE_W-1:0];
                LAT_HI:           rbyte = frz_q[CNT_W-1:BYTE_W];
                LAT_NONE: begin
                    if (acc == ACC_HI || (acc == ACC_WORD && rseq_q == SEQ_HI))
                        rbyte = live[CNT_W-1:BYTE_W];
                    else
                        rbyte = live[BYTE_W-1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cmd_t         cmd,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              pop,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic              cfg_wr,
    output logic [BYTE_W-1:0] rbyte
);

    acc_e acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_LATCH;
            mode   <= '0;
            bcd    <= 1'b0;
            cfg_wr <= 1'b0;
        end else begin
            cfg_wr <= cmd.prog;
            if (cmd.prog) begin
                acc_q <= cmd.acc;
                mode  <= cmd.mode;
                bcd   <= cmd.bcd;
            end
        end
    end

    tmr_wr_seq u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog     (cmd.prog),
        .acc      (acc_q),
        .data_wr  (data_wr),
        .wbyte    (wbyte),
        .load     (load),
        .load_val (load_val)
    );

    tmr_rd_port u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog       (cmd.prog),
        .latch_cnt  (cmd.latch_cnt),
        .latch_stat (cmd.latch_stat),
        .acc        (acc_q),
        .mode       (mode),
        .bcd        (bcd),
        .live       (live),
        .out_lvl    (out_lvl),
        .pop        (pop),
        .rbyte      (rbyte)
    );

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [BYTE_W-1:0]          bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]    ch_count,
    input  logic [NUM_CH-1:0]          ch_out,
    output logic [NUM_CH-1:0]          ch_load,
    output logic [NUM_CH*CNT_W-1:0]    ch_load_val,
    output logic [NUM_CH*MODE_W-1:0]   ch_mode,
    output logic [NUM_CH-1:0]          ch_bcd,
    output logic [NUM_CH-1:0]          ch_cfg_wr
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    chan_cmd_t [NUM_CH-1:0]   cmd;
    logic      [BYTE_W-1:0]   rbyte [NUM_CH];

    tmr_ctrl_decode u_dec (
        .ctrl_wr   (bus_wr && bus_addr == CTRL_ADDR),
        .ctrl_byte (bus_wdata),
        .cmd       (cmd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        tmr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd[i]),
            .data_wr  (bus_wr && bus_addr == MY_ADDR),
            .wbyte    (bus_wdata),
            .pop      (bus_rd && bus_addr == MY_ADDR),
            .live     (ch_count[i*CNT_W +: CNT_W]),
            .out_lvl  (ch_out[i]),
            .load     (ch_load[i]),
            .load_val (ch_load_val[i*CNT_W +: CNT_W]),
            .mode     (ch_mode[i*MODE_W +: MODE_W]),
            .bcd      (ch_bcd[i]),
            .cfg_wr   (ch_cfg_wr[i]),
            .rbyte    (rbyte[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = rbyte[i];
    end

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
    import tmr_regif_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [BYTE_W-1:0]        bus_wdata,
    input logic [NUM_CH-1:0]        ch_load,
    input logic [NUM_CH*MODE_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]        ch_cfg_wr
);

    // R1
    cfg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_cfg_wr) |-> $past(bus_wr && bus_addr == 2'd3 &&
                               bus_wdata[5:4] != 2'b00 && bus_wdata[7:6] != 2'b11));

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode != $past(ch_mode)) |-> (|ch_cfg_wr));

    // R3
    load_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load));

    // R3
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_load) |-> $past(bus_wr && bus_addr != 2'd3));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
        // R2
        mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[i*MODE_W+1 +: 2] != 2'b11);
    end

endmodule

bind tmr_regif tmr_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ch_load   (ch_load),
    .ch_mode   (ch_mode),
    .ch_cfg_wr (ch_cfg_wr)
);

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_out = '0;
    logic [2:0]  ch_load;
    logic [47:0] ch_load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [2:0]  ch_cfg_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_regif u_tmr_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ch_count(ch_count), .ch_out(ch_out), .ch_load(ch_load),
        .ch_load_val(ch_load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_cfg_wr(ch_cfg_wr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(a, d);
        chk(tag, {8'h00, d}, {8'h00, exp});
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        ch_count[ch*16 +: 16] = v;
    endtask

    task automatic t_reset;
        chk("R11 mode", {7'd0, ch_mode}, 16'd0);
        chk("R11 bcd", {13'd0, ch_bcd}, 16'd0);
        chk("R11 load", {13'd0, ch_load}, 16'd0);
        set_live(0, 16'h1234);
        rd_chk(2'd0, 8'h34, "R11 access0 low");
        rd_chk(2'd0, 8'h34, "R11 access0 low again");
        rd_chk(2'd3, 8'h00, "R11 ctrl read");
    endtask

    task automatic t_prog_load;
        wr(2'd3, 8'h34);
        chk("R1 cfg pulse", {13'd0, ch_cfg_wr}, 16'h0001);
        chk("R1 mode ch0", {13'd0, ch_mode[2:0]}, 16'd2);
        wr(2'd0, 8'h78);
        chk("R1 cfg pulse gone", {13'd0, ch_cfg_wr}, 16'd0);
        chk("R3 no load on first", {13'd0, ch_load}, 16'd0);
        wr(2'd0, 8'h56);
        chk("R3 word load", {13'd0, ch_load}, 16'h0001);
        chk("R3 word val", ch_load_val[15:0], 16'h5678);
        @(negedge clk);
        chk("R3 pulse one cycle", {13'd0, ch_load}, 16'd0);
        wr(2'd3, 8'h56);
        chk("R1 mode ch1", {13'd0, ch_mode[5:3]}, 16'd3);
        wr(2'd1, 8'hAB);
        chk("R3 lo load", {13'd0, ch_load}, 16'h0002);
        chk("R3 lo val", ch_load_val[31:16], 16'h00AB);
        wr(2'd3, 8'hA1);
        chk("R1 bcd ch2", {13'd0, ch_bcd}, 16'h0004);
        wr(2'd2, 8'hCD);
        chk("R3 hi val", ch_load_val[47:32], 16'hCD00);
    endtask

    task automatic t_fold;
        wr(2'd3, 8'h5E);
        chk("R2 code7", {13'd0, ch_mode[5:3]}, 16'd3);
        wr(2'd3, 8'h5C);
        chk("R2 code6", {13'd0, ch_mode[5:3]}, 16'd2);
        wr(2'd3, 8'h56);
    endtask

    task automatic t_live;
        wr(2'd3, 8'h34);
        set_live(0, 16'hBEEF);
        rd_chk(2'd0, 8'hEF, "R5 word first low");
        rd_chk(2'd0, 8'hBE, "R5 word then high");
        rd_chk(2'd0, 8'hEF, "R5 word wraps");
        set_live(2, 16'h5A3C);
        rd_chk(2'd2, 8'h5A, "R5 hi only");
        rd_chk(2'd2, 8'h5A, "R5 hi only again");
    endtask

    task automatic t_latch;
        wr(2'd3, 8'h34);
        set_live(0, 16'h1111);
        wr(2'd3, 8'h00);
        set_live(0, 16'h2222);
        rd_chk(2'd0, 8'h11, "R6 frozen low");
        wr(2'd3, 8'h00);
        set_live(0, 16'h3333);
        rd_chk(2'd0, 8'h11, "R6 relatch ignored");
        rd_chk(2'd0, 8'h33, "R7 released live low");
        rd_chk(2'd0, 8'h33, "R7 released live high");
        set_live(1, 16'h4455);
        wr(2'd3, 8'h40);
        set_live(1, 16'h6677);
        rd_chk(2'd1, 8'h55, "R7 lo frozen");
        rd_chk(2'd1, 8'h77, "R7 lo released");
    endtask

    task automatic t_status;
        ch_out = 3'b100;
        wr(2'd3, 8'hEC);
        rd_chk(2'd2, 8'hA1, "R9 status ch2");
        rd_chk(2'd2, 8'h5A, "R9 status released");
        rd_chk(2'd1, 8'h16, "R8 status ch1");
        wr(2'd3, 8'hE4);
        ch_out[1] = 1'b1;
        wr(2'd3, 8'hE4);
        rd_chk(2'd1, 8'h16, "R9 second capture ignored");
        rd_chk(2'd1, 8'h77, "R9 then live");
    endtask

    task automatic t_rb_both;
        wr(2'd3, 8'h34);
        ch_out[0] = 1'b1;
        set_live(0, 16'h4321);
        wr(2'd3, 8'hC2);
        set_live(0, 16'h9999);
        rd_chk(2'd0, 8'hB4, "R9 status before count");
        rd_chk(2'd0, 8'h21, "R7 frozen low");
        rd_chk(2'd0, 8'h43, "R7 frozen high");
        rd_chk(2'd0, 8'h99, "R7 live after");
        set_live(0, 16'h0102); set_live(1, 16'h0304); set_live(2, 16'h0506);
        wr(2'd3, 8'hDE);
        ch_count = '0;
        rd_chk(2'd0, 8'h02, "R8 multi ch0 low");
        rd_chk(2'd0, 8'h01, "R8 multi ch0 high");
        rd_chk(2'd1, 8'h04, "R8 multi ch1");
        rd_chk(2'd2, 8'h05, "R8 multi ch2");
    endtask

    task automatic t_none;
        set_live(1, 16'hABCD);
        wr(2'd3, 8'hC0);
        chk("R10 no cfg pulse", {13'd0, ch_cfg_wr}, 16'd0);
        set_live(1, 16'hEF12);
        rd_chk(2'd1, 8'h12, "R10 no latch");
        chk("R10 modes kept", {7'd0, ch_mode}, {7'd0, 3'd0, 3'd3, 3'd2});
    endtask

    task automatic t_seq_reset;
        wr(2'd3, 8'h34);
        wr(2'd0, 8'hEE);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h11);
        chk("R4 write seq reset", {13'd0, ch_load}, 16'd0);
        wr(2'd0, 8'h22);
        chk("R4 word after reset", ch_load_val[15:0], 16'h2211);
        set_live(0, 16'hC3D4);
        rd_chk(2'd0, 8'hD4, "R4 read low");
        wr(2'd3, 8'h34);
        rd_chk(2'd0, 8'hD4, "R4 read seq reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_prog_load;
        t_fold;
        t_live;
        t_latch;
        t_status;
        t_rb_both;
        t_none;
        t_seq_reset;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule